// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block gives a small device a serial test port in the style of IEEE 1149.1. A sixteen-state controller runs on the test clock and steers a 4-bit instruction register and three data registers. All three data registers sit between the serial input and the serial output. The first is a one-bit bypass stage. The second is a 32-bit identification word. The third is a boundary register sized by parameter, with one cell for each input-only pin and one shared cell for each bidirectional pin. An active-low asynchronous reset input forces the controller into its reset state. Holding the mode input high for five clocks does the same.

The decoded instruction chooses the data register for each scan. It also drives two pad controls. The first is an output select that hands the bidirectional pads to the boundary update latches. The second is an output enable that releases the pads to high impedance. The pad drivers and the functional core are outside the block. The core appears as plain input ports, and the pads appear as a value bus plus one enable.

Top module: `scan_access_port`

## Requirements
- R1: The controller follows the standard sixteen-state TMS transition graph on the rising TCK edge. `trst_n` low forces Test-Logic-Reset at once, without a clock. Any state reaches Test-Logic-Reset after five TCK edges with TMS high, and the controller stays there while TMS stays high.
- R2: Test-Logic-Reset makes opcode 0x2 (identify) current. A data scan then returns the word {version[31:28], part[27:12], maker[11:1], 1'b1}, least-significant bit first. With the default parameters this word is 0x00437067.
- R3: In Capture-IR the instruction shift stage loads 4'b0001. An instruction scan therefore shifts out 1, 0, 0, 0 first.
- R4: The shifted opcode becomes current only on the falling TCK edge in Update-IR. Until that edge the pad controls keep the previous instruction's values. The opcode map is 0x0 external-drive, 0x1 sample/preload, 0x2 identify, 0x3 float, 0x8 hold, 0xF bypass.
- R5: The bypass stage is one bit and captures 0 in Capture-DR. Opcodes 0x3, 0x8, 0xF and every unlisted code select it, so a scan returns 0 followed by the input delayed by one clock.
- R6: The boundary register is NUM_IN+NUM_IO bits long. Bit i below NUM_IN captures `pad_in[i]`. Bit NUM_IN+j captures `io_pad_in[j]`. Bit 0 is nearest TDO, and TDI enters at the top bit.
- R7: Under opcode 0x0, `pad_out` equals the update latches of the bidirectional cells, and `test_sel` is 1.
- R8: Under opcode 0x1, `pad_out` follows `core_io_out`. Data shifted in during this opcode is preloaded into the update latches, and a later opcode 0x0 drives it.
- R9: Under opcode 0x3, `pad_oe` is 0. Under every other opcode it is 1.
- R10: Under opcode 0x8, `test_sel` is 1 and `pad_out` holds the latched boundary values, while scans pass through the bypass stage.
- R11: The update latches change only on the falling TCK edge in Update-DR with the boundary register selected. The pads stay steady while data is shifting.
- R12: TDO and its enable change on the falling TCK edge. `tdo_oe` is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid when tdo_oe is 1 |
| tdo_oe | output | 1 | Enable for the TDO driver |
| pad_in | input | NUM_IN | Values seen on the input-only pins |
| io_pad_in | input | NUM_IO | Values seen on the bidirectional pins |
| core_io_out | input | NUM_IO | Functional values for the bidirectional pins |
| pad_out | output | NUM_IO | Values sent to the bidirectional pad drivers |
| pad_oe | output | 1 | Pad driver enable; 0 floats every output |
| test_sel | output | 1 | 1 when the boundary latches own the pads |

## Verification
The assertions assume that TMS and TDI are steady around each rising TCK edge. They also assume that `trst_n` is taken low and released only while TCK is low, and that TCK keeps toggling while `trst_n` is low, so that the history the assertions sample starts from reset values. The bench changes TMS and TDI only while TCK is low and pulses several clocks during each reset. It holds the pin inputs constant during each scan, so the captured value is defined.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int IR_W  = 4;
  localparam int ID_W  = 32;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {
    PATH_BYP,
    PATH_ID,
    PATH_BSR
  } dr_path_t;

  localparam logic [IR_W-1:0] OP_EXT    = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h1;
  localparam logic [IR_W-1:0] OP_IDENT  = 4'h2;
  localparam logic [IR_W-1:0] OP_FLOAT  = 4'h3;
  localparam logic [IR_W-1:0] OP_HOLD   = 4'h8;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/sap_tap_fsm.sv
module sap_tap_fsm
  import sap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_RESET:  state_d = tms ? S_RESET  : S_IDLE;
      S_IDLE:   state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms ? S_UPD_DR : S_PA_DR;
      S_PA_DR:  state_d = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: state_d = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms ? S_UPD_IR : S_PA_IR;
      S_PA_IR:  state_d = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: state_d = tms ? S_SEL_DR : S_IDLE;
      default:  state_d = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= S_RESET;
    else         state_q <= state_d;
  end

  assign state = state_q;

  // Reset state is sticky while TMS stays high
  assert_reset_sticky_R1: assert property (
    @(posedge tck) disable iff (!trst_n)
    (state_q == S_RESET && tms) |=> (state_q == S_RESET));

endmodule

// File: rtl/sap_instr.sv
module sap_instr
  import sap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       ir_tdo,
  output dr_path_t   path,
  output logic       ext_drive,
  output logic       highz
);

  logic [IR_W-1:0] sh_q, sh_d;
  logic            sh_en;
  logic [IR_W-1:0] cur_q, cur_d;
  logic            cur_en;

  // Shift stage, rising edge
  always_comb begin
    sh_en = (state == S_CAP_IR) || (state == S_SH_IR);
    sh_d  = (state == S_CAP_IR) ? IR_CAPTURE : {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    sh_q <= IR_CAPTURE;
    else if (sh_en) sh_q <= sh_d;
  end

  // Current instruction, falling edge
  always_comb begin
    cur_en = (state == S_UPD_IR) || (state == S_RESET);
    cur_d  = (state == S_RESET) ? OP_IDENT : sh_q;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     cur_q <= OP_IDENT;
    else if (cur_en) cur_q <= cur_d;
  end

  // Decode
  always_comb begin
    path      = PATH_BYP;
    ext_drive = 1'b0;
    highz     = 1'b0;
    case (cur_q)
      OP_EXT:    begin path = PATH_BSR; ext_drive = 1'b1; end
      OP_SAMPLE: path = PATH_BSR;
      OP_IDENT:  path = PATH_ID;
      OP_FLOAT:  highz = 1'b1;
      OP_HOLD:   ext_drive = 1'b1;
      default:   path = PATH_BYP;
    endcase
  end

  assign ir_tdo = sh_q[0];

  assert_capture_pattern_R3: assert property (
    @(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (sh_q[1:0] == 2'b01));

  // Sampled state is the state held during the falling edge just passed
  assert_instr_only_on_update_R4: assert property (
    @(posedge tck) disable iff (!trst_n)
    (state != S_UPD_IR && state != S_RESET) |-> $stable(cur_q));

endmodule

// File: rtl/sap_data_regs.sv
module sap_data_regs
  import sap_pkg::*;
#(
  parameter int          NUM_IN  = 6,
  parameter int          NUM_IO  = 4,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_t        state,
  input  dr_path_t          path,
  input  logic [NUM_IN-1:0] pad_in,
  input  logic [NUM_IO-1:0] io_pad_in,
  output logic              dr_tdo,
  output logic [NUM_IO-1:0] upd_io
);

  localparam int BSR_LEN = NUM_IN + NUM_IO;

  logic capture, shifting;
  assign capture  = (state == S_CAP_DR);
  assign shifting = (state == S_SH_DR);

  // Bypass stage
  logic byp_q, byp_d, byp_en;
  always_comb begin
    byp_en = (path == PATH_BYP) && (capture || shifting);
    byp_d  = shifting ? tdi : 1'b0;
  end
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  // Identification word
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;
  always_comb begin
    id_en = (path == PATH_ID) && (capture || shifting);
    id_d  = capture ? ID_WORD : {tdi, id_q[ID_W-1:1]};
  end
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    id_q <= ID_WORD;
    else if (id_en) id_q <= id_d;
  end

  // Boundary cells
  logic [BSR_LEN-1:0] bsr_q, bsr_d, cap_vec, shin;
  logic               bsr_en;
  assign cap_vec = {io_pad_in, pad_in};

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i == BSR_LEN - 1) begin : g_top
      assign shin[i] = tdi;
    end else begin : g_mid
      assign shin[i] = bsr_q[i+1];
    end
    assign bsr_d[i] = capture ? cap_vec[i] : shin[i];
  end

  assign bsr_en = (path == PATH_BSR) && (capture || shifting);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     bsr_q <= '0;
    else if (bsr_en) bsr_q <= bsr_d;
  end

  // Update latches for the bidirectional cells, falling edge
  logic [NUM_IO-1:0] upd_q;
  logic              upd_en;
  assign upd_en = (state == S_UPD_DR) && (path == PATH_BSR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     upd_q <= '0;
    else if (upd_en) upd_q <= bsr_q[BSR_LEN-1:NUM_IN];
  end

  assign upd_io = upd_q;

  always_comb begin
    case (path)
      PATH_ID:  dr_tdo = id_q[0];
      PATH_BSR: dr_tdo = bsr_q[0];
      default:  dr_tdo = byp_q;
    endcase
  end

  assert_bypass_captures_zero_R5: assert property (
    @(posedge tck) disable iff (!trst_n)
    (capture && path == PATH_BYP) |=> (byp_q == 1'b0));

  assert_update_only_in_upd_dr_R11: assert property (
    @(posedge tck) disable iff (!trst_n)
    (state != S_UPD_DR) |-> $stable(upd_q));

endmodule

// File: rtl/scan_access_port.sv
module scan_access_port
  import sap_pkg::*;
#(
  parameter int          NUM_IN     = 6,
  parameter int          NUM_IO     = 4,
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [15:0] ID_PART    = 16'h0437,
  parameter logic [10:0] ID_MAKER   = 11'h033
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic [NUM_IN-1:0] pad_in,
  input  logic [NUM_IO-1:0] io_pad_in,
  input  logic [NUM_IO-1:0] core_io_out,
  output logic [NUM_IO-1:0] pad_out,
  output logic              pad_oe,
  output logic              test_sel
);

  localparam logic [31:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tap_state_t        state;
  dr_path_t          path;
  logic              ir_tdo, dr_tdo, ext_drive, highz;
  logic [NUM_IO-1:0] upd_io;

  sap_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  sap_instr u_instr (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .state     (state),
    .ir_tdo    (ir_tdo),
    .path      (path),
    .ext_drive (ext_drive),
    .highz     (highz)
  );

  sap_data_regs #(
    .NUM_IN  (NUM_IN),
    .NUM_IO  (NUM_IO),
    .ID_WORD (ID_WORD)
  ) u_dregs (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .state     (state),
    .path      (path),
    .pad_in    (pad_in),
    .io_pad_in (io_pad_in),
    .dr_tdo    (dr_tdo),
    .upd_io    (upd_io)
  );

  // Serial output, falling edge
  logic tdo_q, tdo_d, oe_q, oe_d;
  always_comb begin
    oe_d  = (state == S_SH_IR) || (state == S_SH_DR);
    tdo_d = !oe_d ? 1'b0 : ((state == S_SH_IR) ? ir_tdo : dr_tdo);
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo      = tdo_q;
  assign tdo_oe   = oe_q;
  assign test_sel = ext_drive;
  assign pad_oe   = !highz;
  assign pad_out  = ext_drive ? upd_io : core_io_out;

  assert_tdo_enable_in_shift_R12: assert property (
    @(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state == S_SH_IR) || (state == S_SH_DR)));

endmodule

// File: tb/tb_scan_access_port.sv
module tb_scan_access_port;

  localparam int PERIOD = 10;
  localparam int NIN    = 6;
  localparam int NIO    = 4;
  localparam int BLEN   = NIN + NIO;
  localparam logic [31:0] EXP_ID = 32'h0043_7067;

  localparam int M_RESET = 0,  M_IDLE = 1,  M_SELDR = 2,  M_CAPDR = 3;
  localparam int M_SHDR  = 4,  M_EX1DR = 5, M_PADR = 6,   M_EX2DR = 7;
  localparam int M_UPDDR = 8,  M_SELIR = 9, M_CAPIR = 10, M_SHIR = 11;
  localparam int M_EX1IR = 12, M_PAIR = 13, M_EX2IR = 14, M_UPDIR = 15;

  logic tck, trst_n, tms, tdi;
  logic tdo, tdo_oe, pad_oe, test_sel;
  logic [NIN-1:0] pad_in;
  logic [NIO-1:0] io_pad_in, core_io_out, pad_out;

  scan_access_port #(.NUM_IN(NIN), .NUM_IO(NIO)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe),
    .pad_in(pad_in), .io_pad_in(io_pad_in), .core_io_out(core_io_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .test_sel(test_sel)
  );

  int nchk = 0;
  int nfail = 0;

  // Behavioural reference
  int mst;
  int ir_act;
  bit irq[$];
  bit drq[$];
  bit [NIO-1:0] mupd;
  bit exp_oe, exp_tdo;
  bit pre_oe, pre_sel;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int s, input bit m);
    case (s)
      M_RESET: return m ? M_RESET : M_IDLE;
      M_IDLE:  return m ? M_SELDR : M_IDLE;
      M_SELDR: return m ? M_SELIR : M_CAPDR;
      M_CAPDR: return m ? M_EX1DR : M_SHDR;
      M_SHDR:  return m ? M_EX1DR : M_SHDR;
      M_EX1DR: return m ? M_UPDDR : M_PADR;
      M_PADR:  return m ? M_EX2DR : M_PADR;
      M_EX2DR: return m ? M_UPDDR : M_SHDR;
      M_UPDDR: return m ? M_SELDR : M_IDLE;
      M_SELIR: return m ? M_RESET : M_CAPIR;
      M_CAPIR: return m ? M_EX1IR : M_SHIR;
      M_SHIR:  return m ? M_EX1IR : M_SHIR;
      M_EX1IR: return m ? M_UPDIR : M_PAIR;
      M_PAIR:  return m ? M_EX2IR : M_PAIR;
      M_EX2IR: return m ? M_UPDIR : M_SHIR;
      default: return m ? M_SELDR : M_IDLE;
    endcase
  endfunction

  function automatic int mpath();  // 2 boundary, 1 ident, 0 bypass
    if (ir_act == 0 || ir_act == 1) return 2;
    if (ir_act == 2) return 1;
    return 0;
  endfunction

  task automatic model_pos(input bit m, input bit d);
    case (mst)
      M_CAPIR: irq = '{1'b1, 1'b0, 1'b0, 1'b0};
      M_SHIR:  begin void'(irq.pop_front()); irq.push_back(d); end
      M_CAPDR: begin
        drq.delete();
        if (mpath() == 2) begin
          for (int i = 0; i < NIN; i++) drq.push_back(pad_in[i]);
          for (int i = 0; i < NIO; i++) drq.push_back(io_pad_in[i]);
        end else if (mpath() == 1) begin
          for (int i = 0; i < 32; i++) drq.push_back(EXP_ID[i]);
        end else drq.push_back(1'b0);
      end
      M_SHDR:  begin void'(drq.pop_front()); drq.push_back(d); end
      default: ;
    endcase
    mst = nxt(mst, m);
  endtask

  task automatic model_neg();
    if (mst == M_RESET) ir_act = 2;
    if (mst == M_UPDIR) ir_act = {28'd0, irq[3], irq[2], irq[1], irq[0]};
    if (mst == M_UPDDR && mpath() == 2)
      for (int i = 0; i < NIO; i++) mupd[i] = drq[NIN+i];
    exp_oe  = (mst == M_SHIR) || (mst == M_SHDR);
    exp_tdo = (mst == M_SHIR) ? irq[0] : ((mst == M_SHDR) ? drq[0] : 1'b0);
  endtask

  task automatic compare_all();
    bit drv;
    drv = (ir_act == 0) || (ir_act == 8);
    chk("R12 tdo_oe", tdo_oe, exp_oe);
    if (exp_oe) chk("R12 tdo", tdo, exp_tdo);
    chk("R9 pad_oe", pad_oe, (ir_act != 3));
    chk("R10 test_sel", test_sel, drv);
    chk("R7/R8 pad_out", pad_out, drv ? mupd : core_io_out);
  endtask

  task automatic step(input bit m, input bit d);
    tms = m; tdi = d;
    #2 tck = 1'b1;
    model_pos(m, d);
    #(PERIOD/2) tck = 1'b0;
    model_neg();
    #2 compare_all();
    #(PERIOD/2 - 4);
  endtask

  task automatic do_reset();
    trst_n = 1'b0;
    #1;
    mst = M_RESET; ir_act = 2; mupd = '0; drq.delete();
    exp_oe = 1'b0;
    chk("R1 trst forces idle tdo_oe", tdo_oe, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    trst_n = 1'b1;
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] capd);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      capd[i] = tdo;
      step(i == 3, op[i]);
    end
    pre_oe = pad_oe; pre_sel = test_sel;
    step(1, 0); step(0, 0);
  endtask

  bit moved;
  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    logic [NIO-1:0] start;
    dout = '0; moved = 1'b0;
    step(1, 0); step(0, 0); step(0, 0);
    start = pad_out;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (pad_out !== start) moved = 1'b1;
      step(i == n - 1, din[i]);
    end
    if (pad_out !== start) moved = 1'b1;
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(PERIOD * 20000);
    nfail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0]  capd;
    logic [63:0] dout;
    logic [BLEN-1:0] pre, upd2;
    tck = 0; tms = 1; tdi = 0; trst_n = 0;
    pad_in = 6'b101101; io_pad_in = 4'b0110; core_io_out = 4'b0011;
    pre  = 10'b1001110010;
    upd2 = 10'b0110101011;

    do_reset();
    chk("R1 reset tdo_oe", tdo_oe, 0);
    chk("R9 reset pad_oe", pad_oe, 1);
    chk("R8 reset pad_out functional", pad_out, core_io_out);

    scan_dr('0, 32, dout);
    chk("R2 ident word after reset", dout[31:0], EXP_ID);
    chk("R2 ident bit0 fixed", dout[0], 1);

    load_ir(4'hF, capd);
    chk("R3 capture pattern", capd, 4'b0001);
    scan_dr(64'hA5, 8, dout);
    chk("R5 bypass one-stage delay", dout[7:0], 8'h4A);

    load_ir(4'h5, capd);
    scan_dr(64'h3C, 8, dout);
    chk("R5 reserved code acts as bypass", dout[7:0], 8'h78);

    load_ir(4'h1, capd);
    scan_dr({54'd0, pre}, BLEN, dout);
    chk("R6 boundary capture order", dout[BLEN-1:0], {io_pad_in, pad_in});
    chk("R8 sample leaves pads functional", pad_out, core_io_out);
    core_io_out = 4'b1100; #1;
    chk("R8 sample follows core", pad_out, 4'b1100);

    load_ir(4'h0, capd);
    chk("R4 no change before update", pre_sel, 0);
    chk("R7 external drive of preload", pad_out, pre[BLEN-1:NIN]);
    chk("R7 test_sel", test_sel, 1);
    scan_dr({54'd0, upd2}, BLEN, dout);
    chk("R11 pads steady while shifting", moved, 0);
    chk("R6 capture under external drive", dout[BLEN-1:0], {io_pad_in, pad_in});
    chk("R11 new value after update", pad_out, upd2[BLEN-1:NIN]);

    load_ir(4'h8, capd);
    chk("R10 hold keeps latched values", pad_out, upd2[BLEN-1:NIN]);
    scan_dr(64'h9, 4, dout);
    chk("R10 hold scans through bypass", dout[3:0], 4'h2);
    chk("R10 hold after scan", pad_out, upd2[BLEN-1:NIN]);

    load_ir(4'h3, capd);
    chk("R4 float waits for update", pre_oe, 1);
    chk("R9 float disables pads", pad_oe, 0);
    scan_dr(64'h1, 3, dout);
    chk("R5 float uses bypass", dout[2:0], 3'b010);

    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R1 five TMS ones restore pad_oe", pad_oe, 1);
    step(0, 0);
    scan_dr('0, 32, dout);
    chk("R2 ident after TMS reset", dout[31:0], EXP_ID);

    load_ir(4'h0, capd);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R12 shifting enables tdo", tdo_oe, 1);
    #1 trst_n = 0; #1;
    chk("R1 async reset mid-shift", tdo_oe, 0);
    chk("R1 async reset restores functional pads", pad_out, core_io_out);
    do_reset();
    scan_dr('0, 32, dout);
    chk("R2 ident after async reset", dout[31:0], EXP_ID);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule